// File: doc/BRIEF.md
# Scaled-Add Integer Execute Unit

This unit carries out the integer register-to-register operations and the short-immediate operations of a compact instruction set with 24-bit and 16-bit encodings. It works on 32-bit operands. The unit takes the decoded instruction fields, a form select and the two source register values read by the surrounding pipeline. It returns a 32-bit result, the index of the destination register and a write-enable. The register file, memory access and multiplication are handled elsewhere.

Its additions and subtractions can shift the first operand left by 0 to 3 bit positions before the add or subtract, which makes scaled address arithmetic cost a single operation. The short forms pack small constants into the instruction. Their encodings have two irregular cases. In the add-immediate, a zero code stands for minus one. In the move-immediate, sign extension covers only the top quarter of the 7-bit code, so the reachable range is -32 to 95.

The datapath is combinational. A parameter chooses whether a register stage sits at the output. With the register (the default), a result appears one clock after its inputs.

Top module: `scaled_add_exec`

## Requirements
- R1: With form 0 (wide), `op2` values 1, 2 and 3 produce the bitwise AND, OR and XOR of `src_s` and `src_t`. The result is written to the register named by `fld_r`.
- R2: With form 0, `op2` 8 to 11 produce `(src_s << (op2-8)) + src_t`, written to `fld_r`. The arithmetic wraps modulo 2^32.
- R3: With form 0, `op2` 12 to 15 produce `(src_s << (op2-12)) - src_t`, written to `fld_r`. The arithmetic wraps modulo 2^32.
- R4: With form 0, `op2` 6 and `fld_s` 0 produce the two's-complement negation of `src_t`, written to `fld_r`.
- R5: With form 0, `op2` 6 and `fld_s` 1 produce the absolute value of `src_t`, written to `fld_r`. The input 0x80000000 returns 0x80000000.
- R6: Form 2 (short add-immediate) writes `src_s + k` to `fld_r`. Here k is `fld_t` read as an unsigned value, except that a `fld_t` of 0 gives k = -1.
- R7: Form 3 (short move-immediate) applies only when `fld_t` < 8. It writes the 7-bit value `{fld_t[2:0], fld_r}` to the register named by `fld_s`. The value is sign-extended only when `fld_t[2:1]` = 2'b11, so the reachable range is -32 to 95. With `fld_t` >= 8 the form is not a write.
- R8: Form 1 (short add) writes `src_s + src_t` to `fld_r`. Form 4 (short move) writes `src_s` to the register named by `fld_t`.
- R9: Every case outside R1 to R8 is reserved and produces `wb_en` = 0, `wb_data` = 0 and `wb_dst` = 0. This covers wide `op2` 0, 4, 5 and 7, wide `op2` 6 with `fld_s` >= 2, forms 5 to 7, and form 3 with `fld_t` >= 8.
- R10: With the output register on, each result appears one clock after its inputs. While `rst` is high at a clock edge, all three outputs are cleared to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| form_sel | input | 3 | Form: 0 wide, 1 short add, 2 short add-immediate, 3 short move-immediate, 4 short move, 5-7 reserved |
| op2 | input | 4 | Wide-form operation code |
| fld_r | input | 4 | r field |
| fld_s | input | 4 | s field |
| fld_t | input | 4 | t field |
| src_s | input | 32 | Value of the register named by s |
| src_t | input | 32 | Value of the register named by t |
| wb_data | output | 32 | Result |
| wb_dst | output | 4 | Destination register index |
| wb_en | output | 1 | Write-enable |

## Verification
The assertions assume that the inputs are stable around each rising clock edge, because the checks on the decoder and the ALU sample combinational values there. They also assume that every field is driven to 0 or 1, with no unknown bits. The bench therefore changes all inputs only on falling edges and draws every field from the full range of its width. The random stimulus thus covers all reserved codes and all short-immediate codes without producing a value the unit is not built to take.

// File: rtl/sae_pkg.sv
package sae_pkg;

    localparam int DATA_W = 32;
    localparam int IDX_W  = 4;
    localparam int FLD_W  = 4;
    localparam int SH_W   = 2;

    typedef enum logic [2:0] {
        FORM_WIDE  = 3'd0,
        FORM_NADD  = 3'd1,
        FORM_NADDI = 3'd2,
        FORM_NMOVI = 3'd3,
        FORM_NMOV  = 3'd4
    } form_e;

    typedef enum logic [3:0] {
        K_NONE,
        K_AND,
        K_OR,
        K_XOR,
        K_ADDSH,
        K_SUBSH,
        K_NEG,
        K_ABS,
        K_ADDI,
        K_IMM,
        K_MOVS
    } kind_e;

    typedef struct packed {
        kind_e              kind;
        logic [SH_W-1:0]    shamt;
        logic [DATA_W-1:0]  imm;
        logic [IDX_W-1:0]   dst;
        logic               wr;
    } ctrl_t;

    typedef struct packed {
        logic               wr;
        logic [IDX_W-1:0]   dst;
        logic [DATA_W-1:0]  data;
    } wb_t;

    // Short add-immediate: the zero code means minus one.
    function automatic logic [DATA_W-1:0] addi_const(input logic [FLD_W-1:0] code);
        if (code == '0)
            return '1;
        return {{(DATA_W-FLD_W){1'b0}}, code};
    endfunction

    // Short move-immediate: 7-bit value, sign-extended only in its top quarter.
    function automatic logic [DATA_W-1:0] movi_const(input logic [2:0] hi,
                                                     input logic [FLD_W-1:0] lo);
        logic [6:0] v;
        v = {hi, lo};
        if (hi[2:1] == 2'b11)
            return {{(DATA_W-7){1'b1}}, v};
        return {{(DATA_W-7){1'b0}}, v};
    endfunction

endpackage

// File: rtl/sae_decode.sv
module sae_decode
    import sae_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [2:0]       form_sel,
    input  logic [FLD_W-1:0] op2,
    input  logic [FLD_W-1:0] fld_r,
    input  logic [FLD_W-1:0] fld_s,
    input  logic [FLD_W-1:0] fld_t,
    output ctrl_t            ctrl
);

    always_comb begin
        ctrl       = '0;
        ctrl.kind  = K_NONE;
        case (form_sel)
            FORM_WIDE: begin
                ctrl.dst = fld_r;
                ctrl.wr  = 1'b1;
                case (op2)
                    4'd1: ctrl.kind = K_AND;
                    4'd2: ctrl.kind = K_OR;
                    4'd3: ctrl.kind = K_XOR;
                    4'd6: begin
                        if (fld_s == 4'd0)
                            ctrl.kind = K_NEG;
                        else if (fld_s == 4'd1)
                            ctrl.kind = K_ABS;
                    end
                    4'd8, 4'd9, 4'd10, 4'd11: begin
                        ctrl.kind  = K_ADDSH;
                        ctrl.shamt = op2[SH_W-1:0];
                    end
                    4'd12, 4'd13, 4'd14, 4'd15: begin
                        ctrl.kind  = K_SUBSH;
                        ctrl.shamt = op2[SH_W-1:0];
                    end
                    default: ctrl.kind = K_NONE;
                endcase
            end
            FORM_NADD: begin
                ctrl.kind = K_ADDSH;
                ctrl.dst  = fld_r;
                ctrl.wr   = 1'b1;
            end
            FORM_NADDI: begin
                ctrl.kind = K_ADDI;
                ctrl.imm  = addi_const(fld_t);
                ctrl.dst  = fld_r;
                ctrl.wr   = 1'b1;
            end
            FORM_NMOVI: begin
                if (!fld_t[3]) begin
                    ctrl.kind = K_IMM;
                    ctrl.imm  = movi_const(fld_t[2:0], fld_r);
                    ctrl.dst  = fld_s;
                    ctrl.wr   = 1'b1;
                end
            end
            FORM_NMOV: begin
                ctrl.kind = K_MOVS;
                ctrl.dst  = fld_t;
                ctrl.wr   = 1'b1;
            end
            default: ctrl.kind = K_NONE;
        endcase
        if (ctrl.kind == K_NONE) begin
            ctrl.wr  = 1'b0;
            ctrl.dst = '0;
            ctrl.imm = '0;
        end
    end

    assert_addi_nonzero_R6: assert property (@(posedge clk) disable iff (rst)
        (ctrl.kind == K_ADDI) |-> (ctrl.imm != '0 &&
            ($signed(ctrl.imm) == -1 || ctrl.imm <= 15)));

    assert_movi_range_R7: assert property (@(posedge clk) disable iff (rst)
        (ctrl.kind == K_IMM) |->
            ($signed(ctrl.imm) >= -32 && $signed(ctrl.imm) <= 95));

    assert_movi_dest_R7: assert property (@(posedge clk) disable iff (rst)
        (ctrl.kind == K_IMM) |-> (ctrl.dst == fld_s && fld_t < 4'd8));

endmodule

// File: rtl/sae_alu.sv
module sae_alu
    import sae_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  ctrl_t             ctrl,
    input  logic [DATA_W-1:0] src_s,
    input  logic [DATA_W-1:0] src_t,
    output wb_t               wb
);

    logic [DATA_W-1:0] s_scaled;
    logic [DATA_W-1:0] t_neg;
    logic [DATA_W-1:0] result;

    assign s_scaled = src_s << ctrl.shamt;
    assign t_neg    = '0 - src_t;

    always_comb begin
        case (ctrl.kind)
            K_AND:   result = src_s & src_t;
            K_OR:    result = src_s | src_t;
            K_XOR:   result = src_s ^ src_t;
            K_ADDSH: result = s_scaled + src_t;
            K_SUBSH: result = s_scaled - src_t;
            K_NEG:   result = t_neg;
            K_ABS:   result = src_t[DATA_W-1] ? t_neg : src_t;
            K_ADDI:  result = src_s + ctrl.imm;
            K_IMM:   result = ctrl.imm;
            K_MOVS:  result = src_s;
            default: result = '0;
        endcase
    end

    assign wb.wr   = ctrl.wr;
    assign wb.dst  = ctrl.dst;
    assign wb.data = result;

    assert_neg_sum_R4: assert property (@(posedge clk) disable iff (rst)
        (ctrl.kind == K_NEG) |-> ((wb.data + src_t) == '0));

    assert_abs_sign_R5: assert property (@(posedge clk) disable iff (rst)
        (ctrl.kind == K_ABS) |->
            (!wb.data[DATA_W-1] || wb.data == {1'b1, {(DATA_W-1){1'b0}}}));

    assert_and_subset_R1: assert property (@(posedge clk) disable iff (rst)
        (ctrl.kind == K_AND) |-> ((wb.data & ~src_s) == '0 && (wb.data & ~src_t) == '0));

endmodule

// File: rtl/sae_outstage.sv
module sae_outstage
    import sae_pkg::*;
#(
    parameter bit OUT_REG = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  wb_t  wb_d,
    output wb_t  wb_q
);

    generate
        if (OUT_REG) begin : g_reg
            always_ff @(posedge clk) begin
                if (rst)
                    wb_q <= '0;
                else
                    wb_q <= wb_d;
            end

            assert_latency_R10: assert property (@(posedge clk) disable iff (rst)
                1'b1 |=> (wb_q == $past(wb_d)));

            assert_idle_zero_R9: assert property (@(posedge clk) disable iff (rst)
                !wb_q.wr |-> (wb_q.data == '0 && wb_q.dst == '0));
        end else begin : g_wire
            assign wb_q = wb_d;
        end
    endgenerate

endmodule

// File: rtl/scaled_add_exec.sv
module scaled_add_exec
    import sae_pkg::*;
#(
    parameter bit OUT_REG = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [2:0]        form_sel,
    input  logic [FLD_W-1:0]  op2,
    input  logic [FLD_W-1:0]  fld_r,
    input  logic [FLD_W-1:0]  fld_s,
    input  logic [FLD_W-1:0]  fld_t,
    input  logic [DATA_W-1:0] src_s,
    input  logic [DATA_W-1:0] src_t,
    output logic [DATA_W-1:0] wb_data,
    output logic [IDX_W-1:0]  wb_dst,
    output logic              wb_en
);

    ctrl_t ctrl;
    wb_t   wb_comb;
    wb_t   wb_out;

    sae_decode u_decode (
        .clk      (clk),
        .rst      (rst),
        .form_sel (form_sel),
        .op2      (op2),
        .fld_r    (fld_r),
        .fld_s    (fld_s),
        .fld_t    (fld_t),
        .ctrl     (ctrl)
    );

    sae_alu u_alu (
        .clk   (clk),
        .rst   (rst),
        .ctrl  (ctrl),
        .src_s (src_s),
        .src_t (src_t),
        .wb    (wb_comb)
    );

    sae_outstage #(.OUT_REG(OUT_REG)) u_out (
        .clk  (clk),
        .rst  (rst),
        .wb_d (wb_comb),
        .wb_q (wb_out)
    );

    assign wb_data = wb_out.data;
    assign wb_dst  = wb_out.dst;
    assign wb_en   = wb_out.wr;

endmodule

// File: tb/scaled_add_exec_tb_top.sv
module scaled_add_exec_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [2:0]  form_sel = '0;
    logic [3:0]  op2 = '0, fld_r = '0, fld_s = '0, fld_t = '0;
    logic [31:0] src_s = '0, src_t = '0;
    logic [31:0] wb_data;
    logic [3:0]  wb_dst;
    logic        wb_en;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    scaled_add_exec #(.OUT_REG(1'b1)) dut_i (
        .clk(clk), .rst(rst), .form_sel(form_sel), .op2(op2),
        .fld_r(fld_r), .fld_s(fld_s), .fld_t(fld_t),
        .src_s(src_s), .src_t(src_t),
        .wb_data(wb_data), .wb_dst(wb_dst), .wb_en(wb_en)
    );

    function automatic void model(input logic [2:0] f, input logic [3:0] o,
                                  input logic [3:0] r, input logic [3:0] s,
                                  input logic [3:0] t, input logic [31:0] a,
                                  input logic [31:0] b, output logic w,
                                  output logic [3:0] d, output logic [31:0] v,
                                  output string tag);
        w = 1'b0; d = 4'd0; v = 32'd0; tag = "R9";
        case (f)
            3'd0: begin
                if (o >= 4'd1 && o <= 4'd3) begin
                    w = 1'b1; d = r; tag = "R1";
                    v = (o == 4'd1) ? (a & b) : (o == 4'd2) ? (a | b) : (a ^ b);
                end else if (o >= 4'd8 && o <= 4'd11) begin
                    w = 1'b1; d = r; tag = "R2"; v = (a << (o - 4'd8)) + b;
                end else if (o >= 4'd12) begin
                    w = 1'b1; d = r; tag = "R3"; v = (a << (o - 4'd12)) - b;
                end else if (o == 4'd6 && s == 4'd0) begin
                    w = 1'b1; d = r; tag = "R4"; v = -b;
                end else if (o == 4'd6 && s == 4'd1) begin
                    w = 1'b1; d = r; tag = "R5"; v = ($signed(b) < 0) ? -b : b;
                end
            end
            3'd1: begin w = 1'b1; d = r; tag = "R8"; v = a + b; end
            3'd2: begin
                w = 1'b1; d = r; tag = "R6";
                v = (t == 4'd0) ? a - 32'd1 : a + {28'd0, t};
            end
            3'd3: begin
                if (t < 4'd8) begin
                    int val;
                    val = t * 16 + r;
                    if (val >= 96) val = val - 128;
                    w = 1'b1; d = s; tag = "R7"; v = val;
                end else tag = "R7";
            end
            3'd4: begin w = 1'b1; d = t; tag = "R8"; v = a; end
            default: ;
        endcase
    endfunction

    task automatic run_one(input logic [2:0] f, input logic [3:0] o,
                           input logic [3:0] r, input logic [3:0] s,
                           input logic [3:0] t, input logic [31:0] a,
                           input logic [31:0] b);
        logic w; logic [3:0] d; logic [31:0] v; string tag;
        @(negedge clk);
        form_sel = f; op2 = o; fld_r = r; fld_s = s; fld_t = t;
        src_s = a; src_t = b;
        model(f, o, r, s, t, a, b, w, d, v, tag);
        @(posedge clk); #1;
        checks++;
        if (wb_en !== w || wb_dst !== d || wb_data !== v) begin
            fails++;
            $display("FAIL %s: form=%0d op2=%0d r=%0d s=%0d t=%0d got en=%b dst=%0d data=%h exp en=%b dst=%0d data=%h",
                     tag, f, o, r, s, t, wb_en, wb_dst, wb_data, w, d, v);
        end
    endtask

    task automatic check_reset_state(input string when);
        checks++;
        if (wb_en !== 1'b0 || wb_dst !== 4'd0 || wb_data !== 32'd0) begin
            fails++;
            $display("FAIL R10 (%s): got en=%b dst=%0d data=%h exp en=0 dst=0 data=00000000",
                     when, wb_en, wb_dst, wb_data);
        end
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: run did not complete, got hang exp finish");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin : stim
        void'($urandom(32'd20240611));
        // R10: outputs held at zero under reset even with a live instruction on the inputs
        form_sel = 3'd0; op2 = 4'd8; fld_r = 4'd5; src_s = 32'd7; src_t = 32'd9;
        repeat (3) @(posedge clk);
        #1 check_reset_state("initial reset");
        @(negedge clk) rst = 1'b0;

        // R1 logic ops
        run_one(3'd0, 4'd1, 4'd3, 4'd0, 4'd0, 32'hF0F0_1234, 32'h0FF0_FF00);
        run_one(3'd0, 4'd2, 4'd4, 4'd0, 4'd0, 32'hF0F0_1234, 32'h0FF0_FF00);
        run_one(3'd0, 4'd3, 4'd15, 4'd0, 4'd0, 32'hF0F0_1234, 32'h0FF0_FF00);
        // R2 scaled add, each shift, including wrap
        for (int k = 8; k <= 11; k++)
            run_one(3'd0, 4'(k), 4'd2, 4'd0, 4'd0, 32'hC000_0003, 32'd10);
        // R3 scaled subtract, each shift, including borrow
        for (int k = 12; k <= 15; k++)
            run_one(3'd0, 4'(k), 4'd6, 4'd0, 4'd0, 32'd5, 32'd100);
        // R4 negation
        run_one(3'd0, 4'd6, 4'd1, 4'd0, 4'd0, 32'd0, 32'd1);
        run_one(3'd0, 4'd6, 4'd1, 4'd0, 4'd0, 32'd0, 32'd0);
        // R5 absolute value, including most negative
        run_one(3'd0, 4'd6, 4'd7, 4'd1, 4'd0, 32'd0, 32'hFFFF_FFFB);
        run_one(3'd0, 4'd6, 4'd7, 4'd1, 4'd0, 32'd0, 32'd42);
        run_one(3'd0, 4'd6, 4'd7, 4'd1, 4'd0, 32'd0, 32'h8000_0000);
        // R6 short add-immediate: zero code, max code
        run_one(3'd2, 4'd0, 4'd9, 4'd0, 4'd0, 32'd0, 32'd0);
        run_one(3'd2, 4'd0, 4'd9, 4'd0, 4'd15, 32'd100, 32'd0);
        // R7 short move-immediate boundaries
        run_one(3'd3, 4'd0, 4'd0, 4'd11, 4'd6, 32'd0, 32'd0);
        run_one(3'd3, 4'd0, 4'd15, 4'd11, 4'd5, 32'd0, 32'd0);
        run_one(3'd3, 4'd0, 4'd15, 4'd11, 4'd7, 32'd0, 32'd0);
        run_one(3'd3, 4'd0, 4'd3, 4'd2, 4'd0, 32'd0, 32'd0);
        run_one(3'd3, 4'd0, 4'd3, 4'd2, 4'd8, 32'd55, 32'd66);
        // R8 short add and short move
        run_one(3'd1, 4'd0, 4'd12, 4'd0, 4'd0, 32'hFFFF_FFFF, 32'd2);
        run_one(3'd4, 4'd0, 4'd0, 4'd3, 4'd14, 32'hDEAD_BEEF, 32'd1);
        // R9 reserved codes
        run_one(3'd0, 4'd0, 4'd5, 4'd0, 4'd0, 32'd1, 32'd1);
        run_one(3'd0, 4'd4, 4'd5, 4'd0, 4'd0, 32'd1, 32'd1);
        run_one(3'd0, 4'd5, 4'd5, 4'd0, 4'd0, 32'd1, 32'd1);
        run_one(3'd0, 4'd7, 4'd5, 4'd0, 4'd0, 32'd1, 32'd1);
        run_one(3'd0, 4'd6, 4'd5, 4'd2, 4'd0, 32'd1, 32'd1);
        run_one(3'd5, 4'd8, 4'd5, 4'd0, 4'd0, 32'd1, 32'd1);
        run_one(3'd7, 4'd8, 4'd5, 4'd0, 4'd0, 32'd1, 32'd1);

        // R10: reset in mid-run clears outputs
        run_one(3'd0, 4'd8, 4'd4, 4'd0, 4'd0, 32'd3, 32'd4);
        @(negedge clk) rst = 1'b1;
        @(posedge clk); #1 check_reset_state("mid-run reset");
        @(negedge clk) rst = 1'b0;

        // Random mix covering all requirements
        for (int i = 0; i < 3000; i++) begin
            logic [31:0] a, b;
            a = $urandom;
            b = $urandom;
            if (i % 16 == 0) b = 32'h8000_0000;
            run_one(3'($urandom_range(0, 7)), 4'($urandom), 4'($urandom),
                    4'($urandom_range(0, 3) == 0 ? $urandom_range(0, 1) : $urandom),
                    4'($urandom), a, b);
        end

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule